// File: doc/BRIEF.md
# Simultaneous-Sampling Conversion Result Sequencer

This block is the digital timing core of a multi-channel converter that samples every channel at one shared instant and then hands the results out one at a time. An active-low convert-start input opens an acquisition window on its falling edge. The first rising clock edge that sees convert-start high again is the hold instant. At that edge every channel's 14-bit input word and the channel-enable mask are frozen.

From the hold instant the block counts rising clock edges. It presents the first result a fixed number of cycles later and each further result a shorter fixed number of cycles after the one before. Only enabled channels produce a result, in ascending channel order. Each result comes with a one-cycle active-low end-of-conversion strobe. A separate active-low end-of-last-conversion level marks the close of the frame and stays asserted until the next accepted convert-start falling edge. The enclosing logic reads the result word and its channel index while the strobe is low.

Top module: `simsamp_sequencer`

## Requirements
- R1: While `rstN` is low, `eocN` and `eolcN` are 1 and `resultData` and `resultChan` are 0.
- R2: With the hold edge counted as edge 0, the first result's `eocN` low pulse follows rising edge FIRST_LAT (16 by default).
- R3: Each further result follows NEXT_LAT (3 by default) rising edges after the previous one. Results come only for channels whose `chanEnable` bit is 1, in ascending index order, and disabled channels take no time slot.
- R4: `eocN` is low for exactly one clock cycle per result.
- R5: `resultData` equals bits [14*i+13:14*i] of `chanData` as sampled at the hold edge for channel i, with `resultChan` = i. Changes of `chanData` after the hold edge have no effect.
- R6: `eolcN` goes low in the same cycle as the last result's `eocN` pulse and stays low, with no further `eocN` pulse, until a falling edge of `convStartN` is accepted.
- R7: A falling edge is accepted at a rising clock edge where `convStartN` is 0 and was 1 at the previous edge, and only while no frame is in progress. `eolcN` returns to 1 after that edge. A falling edge during a conversion is ignored and does not change the result timing.
- R8: If `chanEnable` is all zero at the hold edge, `eolcN` goes low at edge FIRST_LAT with no `eocN` pulse.
- R9: `resultData` and `resultChan` change only together with an `eocN` low pulse and hold their value otherwise.
- R10: The acquisition window may last any number of cycles. The hold happens at the first edge that sees `convStartN` high, and `chanEnable` is sampled there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| convStartN | input | 1 | Active-low convert start: fall opens acquisition, return high holds |
| chanEnable | input | NUM_CH | Per-channel enable, bit i for channel i |
| chanData | input | NUM_CH*RES_W | Per-channel sample words, channel i at bits [RES_W*i +: RES_W] |
| resultData | output | RES_W | Current result word |
| resultChan | output | $clog2(NUM_CH) | Channel index of the current result |
| eocN | output | 1 | Active-low one-cycle end-of-conversion strobe |
| eolcN | output | 1 | Active-low end-of-last-conversion level |

## Verification
The assertions check on every cycle that the conversion strobe never lasts two cycles and that result fields move only with a strobe. They also check that the end-of-frame level is released only at a cycle that saw convert-start low, and that no strobe appears while a completed frame is still flagged. The cycle-exact latency to the first result, the spacing of later results, the skipping of disabled channels, the frozen sample values and the ignored mid-frame start can only be shown by the bench's scenarios. Its reference model predicts every output on every clock.

// File: rtl/simsamp_pkg.sv
package simsamp_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_ACQ  = 2'd1,
    SEQ_CONV = 2'd2
  } seqState_e;

  // Strobes from the sequencing control to the hold bank.
  typedef struct packed {
    logic capture;  // hold edge: freeze samples and enable mask
    logic advance;  // result slot: release the next pending channel
  } seqStrobe_t;

endpackage

// File: rtl/simsamp_ctrl.sv
module simsamp_ctrl
  import simsamp_pkg::*;
#(
  parameter int FIRST_LAT = 16,
  parameter int NEXT_LAT  = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       convStartN,
  input  logic       pendAny,
  input  logic       pendLast,
  output seqStrobe_t strobe,
  output logic       eocN,
  output logic       eolcN
);

  localparam int MAX_LAT = (FIRST_LAT > NEXT_LAT) ? FIRST_LAT : NEXT_LAT;
  localparam int CNT_W   = $clog2(MAX_LAT + 1);

  seqState_e        state;
  logic             convPrev;
  logic             firstSlot;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;
  logic             fallSeen;
  logic             slotHit;

  always_comb begin
    fallSeen       = convPrev & ~convStartN;
    limit          = firstSlot ? CNT_W'(FIRST_LAT) : CNT_W'(NEXT_LAT);
    slotHit        = (state == SEQ_CONV) && (cnt == limit);
    strobe.capture = (state == SEQ_ACQ) && convStartN;
    strobe.advance = slotHit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= SEQ_IDLE;
      convPrev  <= 1'b1;
      firstSlot <= 1'b0;
      cnt       <= '0;
      eocN      <= 1'b1;
      eolcN     <= 1'b1;
    end else begin
      convPrev <= convStartN;
      eocN     <= 1'b1;
      unique case (state)
        SEQ_IDLE: begin
          if (fallSeen) begin
            state <= SEQ_ACQ;
            eolcN <= 1'b1;
          end
        end
        SEQ_ACQ: begin
          if (convStartN) begin
            state     <= SEQ_CONV;
            cnt       <= CNT_W'(1);
            firstSlot <= 1'b1;
          end
        end
        SEQ_CONV: begin
          if (slotHit) begin
            cnt       <= CNT_W'(1);
            firstSlot <= 1'b0;
            if (pendAny) eocN <= 1'b0;
            if (!pendAny || pendLast) begin
              eolcN <= 1'b0;
              state <= SEQ_IDLE;
            end
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/simsamp_hold_bank.sv
module simsamp_hold_bank
  import simsamp_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int RES_W  = 14,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  seqStrobe_t              strobe,
  input  logic [NUM_CH-1:0]       chanEnable,
  input  logic [NUM_CH*RES_W-1:0] chanData,
  output logic [RES_W-1:0]        resultData,
  output logic [CH_W-1:0]         resultChan,
  output logic                    pendAny,
  output logic                    pendLast
);

  logic [RES_W-1:0]  sampleIn [NUM_CH];
  logic [RES_W-1:0]  held     [NUM_CH];
  logic [NUM_CH-1:0] pending;
  logic [CH_W-1:0]   pick;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_unpack
    assign sampleIn[g] = chanData[g*RES_W +: RES_W];
  end

  // Lowest pending channel wins.
  always_comb begin
    pick = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (pending[i]) pick = CH_W'(i);
    end
    pendAny  = |pending;
    pendLast = pendAny && ((pending & (pending - NUM_CH'(1))) == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_CH; i++) held[i] <= '0;
      pending    <= '0;
      resultData <= '0;
      resultChan <= '0;
    end else if (strobe.capture) begin
      for (int i = 0; i < NUM_CH; i++) held[i] <= sampleIn[i];
      pending <= chanEnable;
    end else if (strobe.advance && pendAny) begin
      resultData    <= held[pick];
      resultChan    <= pick;
      pending[pick] <= 1'b0;
    end
  end

endmodule

// File: rtl/simsamp_sequencer.sv
module simsamp_sequencer
  import simsamp_pkg::*;
#(
  parameter int NUM_CH    = 8,
  parameter int RES_W     = 14,
  parameter int FIRST_LAT = 16,
  parameter int NEXT_LAT  = 3,
  localparam int CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    convStartN,
  input  logic [NUM_CH-1:0]       chanEnable,
  input  logic [NUM_CH*RES_W-1:0] chanData,
  output logic [RES_W-1:0]        resultData,
  output logic [CH_W-1:0]         resultChan,
  output logic                    eocN,
  output logic                    eolcN
);

  seqStrobe_t strobe;
  logic       pendAny;
  logic       pendLast;

  simsamp_ctrl #(
    .FIRST_LAT(FIRST_LAT),
    .NEXT_LAT (NEXT_LAT)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .convStartN(convStartN),
    .pendAny   (pendAny),
    .pendLast  (pendLast),
    .strobe    (strobe),
    .eocN      (eocN),
    .eolcN     (eolcN)
  );

  simsamp_hold_bank #(
    .NUM_CH(NUM_CH),
    .RES_W (RES_W)
  ) u_bank (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .chanEnable(chanEnable),
    .chanData  (chanData),
    .resultData(resultData),
    .resultChan(resultChan),
    .pendAny   (pendAny),
    .pendLast  (pendLast)
  );

endmodule

// File: rtl/simsamp_sequencer_chk.sv
module simsamp_sequencer_chk #(
  parameter int RES_W = 14,
  parameter int CH_W  = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             convStartN,
  input logic [RES_W-1:0] resultData,
  input logic [CH_W-1:0]  resultChan,
  input logic             eocN,
  input logic             eolcN
);

  // R4: strobe never held for two cycles
  p_eoc_one_cycle_r4: assert property (@(posedge clk) disable iff (!rstN)
    !eocN |=> eocN);

  // R9: result fields move only with a strobe
  p_result_stable_r9: assert property (@(posedge clk) disable iff (!rstN)
    eocN |-> ($stable(resultData) && $stable(resultChan)));

  // R6: frame-done level held while convert-start stays high
  p_eolc_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!eolcN && convStartN) |=> !eolcN);

  // R6: no strobe while a completed frame remains flagged
  p_no_eoc_after_done_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!eolcN && !$past(eolcN)) |-> eocN);

  // R7: release of the frame-done level only after convert-start seen low
  p_eolc_release_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(eolcN) |-> !$past(convStartN));

endmodule

bind simsamp_sequencer simsamp_sequencer_chk #(
  .RES_W(RES_W),
  .CH_W (CH_W)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .convStartN(convStartN),
  .resultData(resultData),
  .resultChan(resultChan),
  .eocN      (eocN),
  .eolcN     (eolcN)
);

// File: tb/test_simsamp_sequencer.sv
module test_simsamp_sequencer;

  localparam int NCH   = 8;
  localparam int RW    = 14;
  localparam int FIRST = 16;
  localparam int NEXT  = 3;
  localparam int CW    = 3;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              convStartN = 1'b1;
  logic [NCH-1:0]    chanEnable = '0;
  logic [NCH*RW-1:0] chanData = '0;
  logic [RW-1:0]     resultData;
  logic [CW-1:0]     resultChan;
  logic              eocN;
  logic              eolcN;

  int compared = 0;
  int mismatched = 0;

  always #5 clk = ~clk;

  simsamp_sequencer #(
    .NUM_CH(NCH), .RES_W(RW), .FIRST_LAT(FIRST), .NEXT_LAT(NEXT)
  ) i_simsamp_sequencer (
    .clk(clk), .rstN(rstN), .convStartN(convStartN),
    .chanEnable(chanEnable), .chanData(chanData),
    .resultData(resultData), .resultChan(resultChan),
    .eocN(eocN), .eolcN(eolcN)
  );

  // ---------------- behavioural reference model ----------------
  int          mState;   // 0 waiting, 1 acquiring, 2 converting
  bit          mPrev;
  int          mTick;
  int          mNextAt;
  int          mQ[$];
  logic [RW-1:0] mHeld [NCH];
  logic        expEoc, expEolc;
  logic [RW-1:0] expData;
  int          expChan;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mState = 0; mPrev = 1; mTick = 0; mNextAt = 0; mQ.delete();
      expEoc = 1; expEolc = 1; expData = '0; expChan = 0;
    end else begin
      expEoc = 1;
      if (mState == 0) begin
        if (mPrev && !convStartN) begin mState = 1; expEolc = 1; end
      end else if (mState == 1) begin
        if (convStartN) begin
          mQ.delete();
          for (int i = 0; i < NCH; i++) begin
            mHeld[i] = chanData[i*RW +: RW];
            if (chanEnable[i]) mQ.push_back(i);
          end
          mTick = 0; mNextAt = FIRST; mState = 2;
        end
      end else begin
        mTick++;
        if (mTick == mNextAt) begin
          if (mQ.size() > 0) begin
            expChan = mQ.pop_front();
            expData = mHeld[expChan];
            expEoc  = 0;
          end
          if (mQ.size() == 0) begin expEolc = 0; mState = 0; end
          mNextAt += NEXT;
        end
      end
      mPrev = convStartN;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      check("R2/R3/R4 eocN", int'(eocN), int'(expEoc));
      check("R6/R7/R8 eolcN", int'(eolcN), int'(expEolc));
      check("R5/R9 resultData", int'(resultData), int'(expData));
      check("R5/R9 resultChan", int'(resultChan), expChan);
    end
  end

  task automatic newData();
    for (int i = 0; i < NCH; i++) chanData[i*RW +: RW] = RW'($urandom);
  endtask

  // One frame; glitchAt > 0 pulls convert-start low mid-conversion,
  // holdLow keeps it low past the end of the frame.
  task automatic runFrame(input logic [NCH-1:0] mask, input int acq,
                          input int glitchAt, input bit holdLow);
    int cyc = 0;
    int pulses = 0;
    int firstAt = 0;
    int n = $countones(mask);
    @(negedge clk);
    convStartN = 1'b0;
    newData();
    repeat (acq) @(negedge clk);
    chanEnable = mask;
    convStartN = 1'b1;
    while (cyc < 200) begin
      @(negedge clk);
      cyc++;
      if (cyc == 5) begin newData(); chanEnable = ~mask; end
      if (glitchAt > 0 && cyc == glitchAt) convStartN = 1'b0;
      if (glitchAt > 0 && cyc == glitchAt + 2 && !holdLow) convStartN = 1'b1;
      if (!eocN) begin
        pulses++;
        if (firstAt == 0) firstAt = cyc;
      end
      if (!eolcN) break;
    end
    check("R3 pulse count", pulses, n);
    if (n > 0) check("R2 first result cycle", firstAt, FIRST + 1);
    else check("R8 empty frame end cycle", cyc, FIRST + 1);
    check("R6 frame end cycle", cyc, (n > 0) ? FIRST + 1 + NEXT*(n-1) : FIRST + 1);
    if (holdLow) begin
      repeat (20) begin
        @(negedge clk);
        check("R7 held-low start ignored", int'(eolcN), 0);
      end
      convStartN = 1'b1;
    end
    repeat (4) @(negedge clk);
    check("R6 done level held", int'(eolcN), 0);
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    #1_000_000;
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 eocN in reset", int'(eocN), 1);
    check("R1 eolcN in reset", int'(eolcN), 1);
    check("R1 resultData in reset", int'(resultData), 0);
    check("R1 resultChan in reset", int'(resultChan), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    runFrame(8'hFF, 2, 0, 0);          // R2 R3 R5
    runFrame(8'hA5, 1, 0, 0);          // R3 skip disabled
    runFrame(8'h81, 30, 0, 0);         // R10 long acquisition
    runFrame(8'h7E, 3, 9, 0);          // R7 mid-frame fall ignored
    runFrame(8'h00, 2, 0, 0);          // R8 empty mask
    runFrame(8'h10, 2, 12, 1);         // R7 start held low across frame end
    runFrame(8'h03, 1, 0, 0);          // R9 back-to-back
    repeat (5) @(negedge clk);
    finishRun();
  end

endmodule